// File: doc/BRIEF.md
# Pipelined Second-Order Recursive Filter

This block is a second-order recursive (IIR) filter in signed fixed point. It accepts one 16-bit two's-complement sample on any clock cycle where the sample-valid input is high. One cycle later it presents the filtered 16-bit sample together with its own valid flag. The two feed-forward-side and feedback-side coefficient sets are fixed at elaboration time as module parameters. All coefficients share one fraction width, `CF`. A caller picks the response by choosing those five words and reads one filtered sample per accepted input.

Internally the sum of products is not a direct-form adder chain. Two state registers sit between the taps, in the transposed arrangement that cut-set retiming of the direct form yields. The longest path between registers is therefore two multiply-add stages for any order, and the input-to-output relation is unchanged. Products are kept at full width, and the partial sums are carried in a widened accumulator. Only the output value is rescaled by `CF` bits, rounding toward minus infinity, and clamped to the 16-bit range. The clamped output word is also the value fed back into the recursion.

Top module: `iir2_cutset_filter`

## Requirements
- R1: For each accepted sample, out_y equals clamp16(floor(S / 2^CF)). Here S = B0·x(n) + B1·x(n−1) + B2·x(n−2) − A1·y(n−1) − A2·y(n−2), and x(n−k) and y(n−k) are the previous accepted inputs and outputs. The history starts at zero after reset.
- R2: The feedback coefficients A1 and A2 enter the sum subtracted. With the default A1 = −19661 the response to an impulse rings above the feed-forward-only value from the second accepted sample on.
- R3: When the rescaled sum exceeds 32767 the output is 32767. When it is below −32768 the output is −32768. The output never wraps.
- R4: out_valid is high exactly one clock after a cycle in which in_valid was high and reset was low. It is low one clock after a cycle with in_valid low.
- R5: A cycle with in_valid low changes neither the internal state nor out_y. The next accepted sample continues the same recursion.
- R6: A synchronous reset (rst high at a clock edge) clears out_y to 0, out_valid to 0 and both state words to 0.
- R7: After reset, the first output for an input of amplitude x is floor(B0·x / 2^CF). With defaults B0 = 2048, CF = 14 and x = 16384 this is 2048.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample is valid this cycle |
| in_x | input | DW (16) | Signed input sample |
| out_valid | output | 1 | Output sample is valid |
| out_y | output | DW (16) | Signed filtered sample, held between valid outputs |

## Verification
The assertions watch the cycle-level rules on every clock. They check the one-cycle valid latency, that an idle cycle leaves state and output untouched, and that reset leaves everything at zero. They also check that a positive or negative overflow of the rescaled sum lands on the matching rail. The numerical recursion itself cannot be stated as a simple property: the correct coefficient signs, the floor rescaling and the use of the clamped output in the feedback. Only the bench's impulse, step, random and gapped sequences show these, compared against an independently written difference-equation model.

// File: rtl/iir2_pkg.sv
package iir2_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } iir2_clip_t;

  // Arithmetic right shift: division by 2^sh rounded toward minus infinity.
  function automatic logic signed [63:0] iir2_realign(input logic signed [63:0] v,
                                                      input int unsigned sh);
    return v >>> sh;
  endfunction

  // Largest value representable in a signed w-bit word.
  function automatic logic signed [63:0] iir2_top(input int unsigned w);
    return (64'sd1 <<< (w - 1)) - 64'sd1;
  endfunction

  // Clamp to the signed w-bit range.
  function automatic logic signed [63:0] iir2_clamp(input logic signed [63:0] v,
                                                    input int unsigned w);
    logic signed [63:0] hi;
    logic signed [63:0] lo;
    hi = iir2_top(w);
    lo = -hi - 64'sd1;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic iir2_clip_t iir2_clip_flags(input logic signed [63:0] v,
                                                 input int unsigned w);
    iir2_clip_t f;
    f.hi = (v > iir2_top(w));
    f.lo = (v < (-iir2_top(w) - 64'sd1));
    return f;
  endfunction

endpackage

// File: rtl/iir2_prod_bank.sv
module iir2_prod_bank #(
  parameter int unsigned NT  = 3,
  parameter int unsigned DW  = 16,
  parameter int unsigned CW  = 16,
  parameter int unsigned OW  = 35,
  parameter bit          NEG = 1'b0,
  parameter logic [NT*CW-1:0] COEFS = '0
) (
  input  logic signed [DW-1:0]    din,
  output logic        [NT*OW-1:0] prod
);
  localparam int unsigned PW = DW + CW;

  for (genvar k = 0; k < NT; k++) begin : g_tap
    logic signed [PW-1:0] ce;
    logic signed [PW-1:0] xe;
    logic signed [PW-1:0] pr;
    logic signed [OW-1:0] pw;
    assign ce = PW'($signed(COEFS[k*CW +: CW]));
    assign xe = PW'(din);
    assign pr = ce * xe;
    assign pw = OW'(pr);
    if (NEG) begin : g_neg
      assign prod[k*OW +: OW] = -pw;
    end else begin : g_pos
      assign prod[k*OW +: OW] = pw;
    end
  end
endmodule

// File: rtl/iir2_state_regs.sv
module iir2_state_regs #(
  parameter int unsigned ACW = 35
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  en,
  input  logic signed [ACW-1:0] s1_nx,
  input  logic signed [ACW-1:0] s2_nx,
  output logic signed [ACW-1:0] s1,
  output logic signed [ACW-1:0] s2
);
  always_ff @(posedge clk) begin
    if (rst) begin
      s1 <= '0;
      s2 <= '0;
    end else if (en) begin
      s1 <= s1_nx;
      s2 <= s2_nx;
    end
  end
endmodule

// File: rtl/iir2_cutset_filter.sv
module iir2_cutset_filter
  import iir2_pkg::*;
#(
  parameter int unsigned DW = 16,
  parameter int unsigned CW = 16,
  parameter int unsigned CF = 14,
  parameter logic signed [CW-1:0] B0 = 16'sd2048,
  parameter logic signed [CW-1:0] B1 = 16'sd4096,
  parameter logic signed [CW-1:0] B2 = 16'sd2048,
  parameter logic signed [CW-1:0] A1 = -16'sd19661,
  parameter logic signed [CW-1:0] A2 = 16'sd8192
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic signed [DW-1:0] in_x,
  output logic               out_valid,
  output logic signed [DW-1:0] out_y
);
  localparam int unsigned PW  = DW + CW;
  localparam int unsigned ACW = PW + 3;

  // Feed-forward products b_k*x (k = 0..2) and negated feedback products -a_k*y.
  logic [3*ACW-1:0] ff_flat;
  logic [2*ACW-1:0] fb_flat;
  logic signed [ACW-1:0] ff0, ff1, ff2, fb1, fb2;
  logic signed [ACW-1:0] s1, s2, s1_nx, s2_nx;
  logic signed [ACW-1:0] y_acc;
  logic signed [63:0]    y_wide;
  logic signed [63:0]    y_scaled;
  logic signed [63:0]    y_clamped;
  logic signed [DW-1:0]  y_now;
  iir2_clip_t            clip;
  logic                  sat_hi, sat_lo;
  logic                  step_en;

  iir2_prod_bank #(
    .NT(3), .DW(DW), .CW(CW), .OW(ACW), .NEG(1'b0),
    .COEFS({B2, B1, B0})
  ) ff_bank_i (
    .din (in_x),
    .prod(ff_flat)
  );

  iir2_prod_bank #(
    .NT(2), .DW(DW), .CW(CW), .OW(ACW), .NEG(1'b1),
    .COEFS({A2, A1})
  ) fb_bank_i (
    .din (y_now),
    .prod(fb_flat)
  );

  assign ff0 = ff_flat[0*ACW +: ACW];
  assign ff1 = ff_flat[1*ACW +: ACW];
  assign ff2 = ff_flat[2*ACW +: ACW];
  assign fb1 = fb_flat[0*ACW +: ACW];
  assign fb2 = fb_flat[1*ACW +: ACW];

  // First multiply-add stage: output sum from the leading state word.
  assign y_acc     = ff0 + s1;
  assign y_wide    = 64'(y_acc);
  assign y_scaled  = iir2_realign(y_wide, CF);
  assign y_clamped = iir2_clamp(y_scaled, DW);
  assign clip      = iir2_clip_flags(y_scaled, DW);
  assign sat_hi    = clip.hi;
  assign sat_lo    = clip.lo;
  assign y_now     = y_clamped[DW-1:0];

  // Second multiply-add stage: state words for the next accepted sample.
  assign s1_nx   = ff1 + fb1 + s2;
  assign s2_nx   = ff2 + fb2;
  assign step_en = in_valid;

  iir2_state_regs #(.ACW(ACW)) state_i (
    .clk  (clk),
    .rst  (rst),
    .en   (step_en),
    .s1_nx(s1_nx),
    .s2_nx(s2_nx),
    .s1   (s1),
    .s2   (s2)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_y     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_y <= y_now;
    end
  end
endmodule

// File: rtl/iir2_cutset_chk.sv
module iir2_cutset_chk #(
  parameter int unsigned DW  = 16,
  parameter int unsigned ACW = 35
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  in_valid,
  input logic                  out_valid,
  input logic signed [DW-1:0]  out_y,
  input logic signed [ACW-1:0] s1,
  input logic signed [ACW-1:0] s2,
  input logic                  sat_hi,
  input logic                  sat_lo
);
  localparam logic signed [DW-1:0] YMAX = {1'b0, {(DW-1){1'b1}}};
  localparam logic signed [DW-1:0] YMIN = {1'b1, {(DW-1){1'b0}}};

  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  p_latency_r4: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(s1) && $stable(s2) && $stable(out_y)));

  p_reset_clear_r6: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> (out_y == '0 && !out_valid && s1 == '0 && s2 == '0));

  p_clip_hi_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_hi) |=> (out_y == YMAX));

  p_clip_lo_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_lo) |=> (out_y == YMIN));
endmodule

bind iir2_cutset_filter iir2_cutset_chk #(.DW(DW), .ACW(ACW)) chk_i (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_y    (out_y),
  .s1       (s1),
  .s2       (s2),
  .sat_hi   (sat_hi),
  .sat_lo   (sat_lo)
);

// File: tb/iir2_cutset_filter_tb.sv
`timescale 1ns/1ps
module iir2_cutset_filter_tb_top;
  localparam int CF = 14;
  localparam longint KB0 = 2048;
  localparam longint KB1 = 4096;
  localparam longint KB2 = 2048;
  localparam longint KA1 = -19661;
  localparam longint KA2 = 8192;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic signed [15:0] in_x = '0;
  logic out_valid;
  logic signed [15:0] out_y;

  int nchk = 0;
  int nfail = 0;
  bit done = 1'b0;

  // Model history.
  longint mx1 = 0, mx2 = 0, my1 = 0, my2 = 0;

  always #2 clk = ~clk;

  iir2_cutset_filter #(
    .DW(16), .CW(16), .CF(CF),
    .B0(16'sd2048), .B1(16'sd4096), .B2(16'sd2048),
    .A1(-16'sd19661), .A2(16'sd8192)
  ) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
    .out_valid(out_valid), .out_y(out_y)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint model_out(input longint x);
    longint s;
    longint q;
    s = KB0 * x + KB1 * mx1 + KB2 * mx2 - KA1 * my1 - KA2 * my2;
    q = s >>> CF;
    if (q > 32767) q = 32767;
    if (q < -32768) q = -32768;
    return q;
  endfunction

  task automatic model_clear();
    mx1 = 0; mx2 = 0; my1 = 0; my2 = 0;
  endtask

  // One clock: drive, wait for the edge, then compare away from it.
  task automatic cyc(input bit v, input logic signed [15:0] x, input string tag,
                     output longint got);
    longint e;
    in_valid = v;
    in_x = x;
    @(posedge clk);
    #1;
    got = out_y;
    if (v) begin
      e = model_out(longint'(x));
      check(out_valid == 1'b1, {tag, " R4 valid"}, out_valid, 1);
      check(out_y == e, {tag, " R1 value"}, out_y, e);
      mx2 = mx1; mx1 = x; my2 = my1; my1 = e;
    end else begin
      check(out_valid == 1'b0, "R4 idle valid", out_valid, 0);
      check(out_y == my1, "R5 held output", out_y, my1);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b1;
    in_x = 16'sd12345;
    repeat (2) @(posedge clk);
    #1;
    check(out_y == 0, "R6 reset out_y", out_y, 0);
    check(out_valid == 1'b0, "R6 reset out_valid", out_valid, 0);
    rst = 1'b0;
    in_valid = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    longint g;
    longint g2;
    int seen_hi;
    do_reset();

    // Impulse: first output, then ringing through the feedback path.
    cyc(1'b1, 16'sd16384, "impulse", g);
    check(g == 2048, "R7 first impulse output", g, 2048);
    cyc(1'b1, 16'sd0, "impulse", g);
    cyc(1'b1, 16'sd0, "impulse", g2);
    // Feed-forward alone would give 2048 at the third sample; feedback must lift it.
    check(g2 > 2048, "R2 feedback sign", g2, 2049);
    for (int i = 0; i < 30; i++) cyc(1'b1, 16'sd0, "impulse", g);

    // Positive step into saturation.
    seen_hi = 0;
    for (int i = 0; i < 40; i++) begin
      cyc(1'b1, 16'sd30000, "step_pos", g);
      if (g == 32767) seen_hi++;
    end
    check(g == 32767, "R3 positive rail", g, 32767);
    check(seen_hi > 0, "R3 rail reached", seen_hi, 1);
    // Negative step.
    for (int i = 0; i < 40; i++) cyc(1'b1, -16'sd30000, "step_neg", g);
    check(g == -32768, "R3 negative rail", g, -32768);

    // Random full-scale samples with idle gaps.
    for (int i = 0; i < 600; i++) begin
      bit v;
      v = (($urandom % 4) != 0);
      cyc(v, 16'($urandom), "random_full", g);
    end

    // Mid-run reset, then the impulse again from cleared state.
    do_reset();
    cyc(1'b1, 16'sd16384, "post_reset", g);
    check(g == 2048, "R6 state cleared R7", g, 2048);

    // Small-amplitude random with gaps: linear region.
    for (int i = 0; i < 800; i++) begin
      bit v;
      logic signed [15:0] r;
      v = (($urandom % 3) != 0);
      r = 16'($urandom);
      cyc(v, r >>> 3, "random_small", g);
    end

    // Long idle run followed by resumed input (R5 continuity).
    for (int i = 0; i < 20; i++) cyc(1'b0, 16'sd999, "idle", g);
    for (int i = 0; i < 20; i++) cyc(1'b1, 16'sd1000, "resume R5", g);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule